// File: doc/BRIEF.md
# Configurable SPI Master/Slave Port

This block is a byte-wide serial peripheral interface controller. A processor reaches it through three byte registers: control, status and data. It can act as bus master, where it generates the serial clock from the system clock, or as slave, where it follows a clock from outside. The role is set by a control bit. It can also follow the level of the select input. Clock polarity, clock phase and bit order are all programmable.

To send a byte, software writes it to the data register. The byte waits in a holding register until the shift register is free. When a byte has finished shifting, the received byte appears in the data register, and a sticky completion flag raises the interrupt line. If a master that obeys the select input sees select pulled low, it gives up the bus. It drops to slave, abandons the transfer in progress and signals this through the same completion flag.

Top module: `spi_port`

## Requirements
- R1: After reset the control register (address 0), status register (address 1) and receive data (address 2) all read 0, and `irq`, `sck_o`, `sck_oe` and `miso_oe` are 0. Address 3 reads 0.
- R2: Control bits, MSB first: [7] select-ignore, [6] enable, [5] LSB-first, [4] master, [3] polarity, [2] phase, [1:0] low rate bits. The block is master (`sck_oe`=`mosi_oe`=1) when enable=1, master=1 and either select-ignore=1 or `ss_n_i`=1. Otherwise, with enable=1, it is slave, and it drives `miso_oe` while select-ignore=1 or `ss_n_i`=0.
- R3: When enable=1, master=1, select-ignore=0 and `ss_n_i` is low, the block clears control bit 4 within 4 clocks, sets the completion flag, abandons the transfer and becomes slave.
- R4: While no transfer is running, `sck_o` equals the polarity bit.
- R5: Phase=0 samples on the leading serial-clock edge and changes data on the trailing edge. Phase=1 changes data on the leading edge and samples on the trailing edge. All four polarity/phase modes move a full byte in both directions.
- R6: LSB-first=1 shifts bit 0 first; LSB-first=0 shifts bit 7 first, for both sent and received data.
- R7: In master mode the serial clock period is N system clocks, where the rate code {status[0], control[1:0]} = 0..7 selects N = 4, 6, 8, 12, 16, 24, 48, 96.
- R8: Status bit 7 is the completion flag. It sets after the 16th serial-clock edge of a byte, `irq` follows it, writing 1 to it clears it, and writing 0 leaves it set.
- R9: Status bit 6 (holding full) becomes 1 on a write to address 2. It returns to 0 when the byte moves into the shift register.
- R10: A byte waiting in the holding register when a master byte ends starts at once: the first edge of the new byte follows the last edge of the previous one after one half period.
- R11: With enable=0 no serial clock toggles, no output enable is driven and no transfer completes, even with a byte written.
- R12: In slave mode the block shifts the holding byte out on `miso_o`, and after 16 external clock edges it stores the received `mosi_i` byte at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 status, 2 data) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| irq | output | 1 | Completion interrupt |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock drive enable |
| mosi_i | input | 1 | Master-out data in (slave) |
| mosi_o | output | 1 | Master-out data out |
| mosi_oe | output | 1 | Master-out drive enable |
| miso_i | input | 1 | Master-in data in (master) |
| miso_o | output | 1 | Master-in data out |
| miso_oe | output | 1 | Master-in drive enable |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The hardest cases to reach are the chained transfer and the forced loss of mastership. For the chained transfer, the next byte must reach the holding register while the current byte is still shifting. For the loss of mastership, select must fall in the middle of a slow master byte. The bench polls the holding-full bit and writes the second byte as soon as the first one has left. It then measures the span from the first to the 32nd clock edge against 31 half periods. For the mode change it starts a transfer at the slowest rate and pulls select low part way through, then reads back the control and status registers and the output enables. A sweep over all four modes, both bit orders and all eight rates checks data in both directions and the clock period against a behavioural slave.

// File: rtl/spi_port.sv
module spi_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       ss_n_i
);
  localparam int BITS  = 8;
  localparam int EDGES = 2 * BITS;
  localparam int CW    = $clog2(EDGES);

  function automatic logic [5:0] half_of(input logic [2:0] s);
    case (s)
      3'd0:    half_of = 6'd2;
      3'd1:    half_of = 6'd3;
      3'd2:    half_of = 6'd4;
      3'd3:    half_of = 6'd6;
      3'd4:    half_of = 6'd8;
      3'd5:    half_of = 6'd12;
      3'd6:    half_of = 6'd24;
      default: half_of = 6'd48;
    endcase
  endfunction

  logic [7:0]    ctrl_q, hold_q, tx_sh, rx_sh, rx_q;
  logic          rate2_q, flag_q, hold_full_q, busy_q, ph_q;
  logic [CW-1:0] cnt_q;
  logic [5:0]    div_q;
  logic          ss_m, ss_s, sck_m, sck_s, sck_d, mosi_m, mosi_s;

  wire ign  = ctrl_q[7];
  wire en   = ctrl_q[6];
  wire lsbf = ctrl_q[5];
  wire mst  = ctrl_q[4];
  wire cpol = ctrl_q[3];
  wire cpha = ctrl_q[2];

  wire [5:0] half = half_of({rate2_q, ctrl_q[1:0]});

  wire role_master = en & mst & (ign | ss_s);
  wire role_slave  = en & ~role_master;
  wire slave_sel   = role_slave & (ign | ~ss_s);
  wire mode_chg    = en & mst & ~ign & ~ss_s;

  wire m_tick = role_master & busy_q & (div_q == half - 6'd1);
  wire s_tick = slave_sel & (sck_s != sck_d);
  wire tick   = m_tick | s_tick;

  wire lead  = ~cnt_q[0];
  wire first = (cnt_q == '0);
  wire final_e = (cnt_q == CW'(EDGES - 1));
  wire samp  = tick & (lead ^ cpha);
  wire shft  = tick & (cpha ? (lead & ~first) : (~lead & ~final_e));
  wire last  = tick & final_e;

  wire       din   = role_master ? miso_i : mosi_s;
  wire [7:0] rx_nx = lsbf ? {din, rx_sh[7:1]} : {rx_sh[6:0], din};
  wire       dout  = lsbf ? tx_sh[0] : tx_sh[7];

  wire m_start = role_master & ~busy_q & hold_full_q;
  wire s_load  = role_slave & first & ~tick & hold_full_q;
  wire load    = m_start | s_load | (last & hold_full_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; hold_q <= '0; tx_sh <= '0; rx_sh <= '0; rx_q <= '0;
      rate2_q <= 1'b0; flag_q <= 1'b0; hold_full_q <= 1'b0; busy_q <= 1'b0;
      ph_q <= 1'b0; cnt_q <= '0; div_q <= '0;
      ss_m <= 1'b1; ss_s <= 1'b1; sck_m <= 1'b0; sck_s <= 1'b0; sck_d <= 1'b0;
      mosi_m <= 1'b0; mosi_s <= 1'b0;
    end else begin
      ss_m <= ss_n_i;  ss_s <= ss_m;
      sck_m <= sck_i;  sck_s <= sck_m;  sck_d <= sck_s;
      mosi_m <= mosi_i; mosi_s <= mosi_m;

      if (load) begin
        tx_sh <= hold_q;
        hold_full_q <= 1'b0;
      end else if (shft) begin
        tx_sh <= lsbf ? {1'b0, tx_sh[7:1]} : {tx_sh[6:0], 1'b0};
      end
      if (samp) rx_sh <= rx_nx;
      if (last) rx_q <= samp ? rx_nx : rx_sh;

      if (wr_en) begin
        case (wr_addr)
          2'd0: ctrl_q <= wr_data;
          2'd1: begin
            if (wr_data[7]) flag_q <= 1'b0;
            rate2_q <= wr_data[0];
          end
          2'd2: begin
            hold_q <= wr_data;
            hold_full_q <= 1'b1;
          end
          default: ;
        endcase
      end

      if (tick) cnt_q <= cnt_q + 1'b1;
      if (m_start) cnt_q <= '0;
      if (!role_master && !slave_sel) cnt_q <= '0;

      if (m_start) busy_q <= 1'b1;
      else if (last && role_master && !hold_full_q) busy_q <= 1'b0;
      if (!role_master) busy_q <= 1'b0;

      if (m_start || !busy_q) div_q <= '0;
      else div_q <= m_tick ? 6'd0 : div_q + 6'd1;

      if (m_tick) ph_q <= ~ph_q;
      if (!role_master) ph_q <= 1'b0;

      if (last || mode_chg) flag_q <= 1'b1;
      if (mode_chg) ctrl_q[4] <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = ctrl_q;
      2'd1:    rd_data = {flag_q, hold_full_q, 5'b0, rate2_q};
      2'd2:    rd_data = rx_q;
      default: rd_data = '0;
    endcase
  end

  assign irq     = flag_q;
  assign sck_o   = cpol ^ ph_q;
  assign sck_oe  = role_master;
  assign mosi_o  = dout;
  assign mosi_oe = role_master;
  assign miso_o  = dout;
  assign miso_oe = slave_sel;

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (role_master && !busy_q) |-> (sck_o == cpol)); // R4
  AST_CLEAR_W1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && wr_data[7] && !last && !mode_chg) |=> !flag_q); // R8
  AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |=> hold_full_q); // R9
  AST_MODE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (!ctrl_q[4] && flag_q)); // R3
  AST_ROLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sck_oe, miso_oe})); // R2
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!sck_oe && !miso_oe && !busy_q)); // R11
endmodule

// File: tb/tb_spi_port.sv
module tb_spi_port;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, miso_i;
  logic sck_i = 0, mosi_i = 0, ss_n_i = 1;

  spi_port dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o),
    .miso_oe(miso_oe), .ss_n_i(ss_n_i));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural slave for master tests
  logic b_cpha = 0, b_lsb = 0, sl_prev = 0, lead;
  logic [7:0] sl_tx = 0, sl_rx = 0, sl_last = 0, sl_b0 = 0;
  logic [2:0] oidx = 0, iidx = 0;
  int sl_cnt = 0, nedges = 0, t_first = 0, t_last = 0, sl_bytes = 0;
  assign miso_i = b_lsb ? sl_tx[oidx] : sl_tx[3'd7 - oidx];

  always @(negedge clk) begin
    if (sck_o != sl_prev) begin
      sl_prev = sck_o;
      lead = (sl_cnt % 2) == 0;
      if (nedges == 0) t_first = cyc;
      t_last = cyc;
      nedges++;
      if (lead ^ b_cpha) begin
        sl_rx[b_lsb ? iidx : 3'd7 - iidx] = mosi_o;
        iidx++;
      end
      if (b_cpha ? (lead && sl_cnt != 0) : (!lead && sl_cnt != 15)) oidx++;
      if (sl_cnt == 15) begin
        sl_cnt = 0; oidx = 0; iidx = 0; sl_last = sl_rx;
        if (sl_bytes == 0) sl_b0 = sl_rx;
        sl_bytes++;
      end else sl_cnt++;
    end
  end

  task automatic sl_reset(input logic cp, input logic ls, input logic [7:0] tx);
    @(negedge clk); #1;
    b_cpha = cp; b_lsb = ls; sl_tx = tx; sl_prev = sck_o;
    sl_cnt = 0; oidx = 0; iidx = 0; nedges = 0; sl_bytes = 0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1; d = rd_data;
  endtask

  task automatic do_reset;
    rst_n = 0; ss_n_i = 1; sck_i = 0; mosi_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  // bench master for slave tests, half period 16 clocks
  task automatic ext_master(input logic cpol, input logic cpha, input logic [7:0] tx,
                            output logic [7:0] got);
    got = 0;
    @(negedge clk); sck_i = cpol; ss_n_i = 0;
    repeat (16) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      if (!cpha) mosi_i = tx[i];
      repeat (16) @(negedge clk);
      sck_i = ~cpol;
      if (cpha) mosi_i = tx[i]; else got[i] = miso_o;
      repeat (16) @(negedge clk);
      sck_i = cpol;
      if (cpha) got[i] = miso_o;
    end
    repeat (16) @(negedge clk);
    ss_n_i = 1;
  endtask

  initial begin : main
    logic [7:0] v, tx, stx, got;
    int nb;
    do_reset();

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 status", v, 0);
    rd(2'd2, v); chk("R1 data", v, 0);
    rd(2'd3, v); chk("R1 addr3", v, 0);
    chk("R1 irq", irq, 0); chk("R1 sck_o", sck_o, 0);
    chk("R1 oe", {sck_oe, miso_oe}, 0);

    // R2 role selection
    ss_n_i = 0;
    wr(2'd0, 8'hD0); repeat (4) @(negedge clk);
    chk("R2 ignore-select master", {sck_oe, mosi_oe, miso_oe}, 3'b110);
    wr(2'd0, 8'h40); repeat (4) @(negedge clk);
    chk("R2 select-driven slave", {sck_oe, miso_oe}, 2'b01);
    ss_n_i = 1;
    wr(2'd0, 8'h50); repeat (4) @(negedge clk);
    chk("R2 select-high master", {sck_oe, miso_oe}, 2'b10);
    rd(2'd1, v); chk("R2 no flag", v[7], 0);

    // R11 disabled
    do_reset();
    wr(2'd0, 8'h90); sl_reset(0, 0, 8'h00);
    wr(2'd2, 8'h77); repeat (300) @(negedge clk);
    chk("R11 no edges", nedges, 0);
    chk("R11 no oe", {sck_oe, mosi_oe, miso_oe}, 0);
    rd(2'd1, v); chk("R11 no flag, byte held", {v[7], v[6]}, 2'b01);

    // sweep: modes x orders x rates (R4 R5 R6 R7 R8)
    for (int m = 0; m < 4; m++)
      for (int o = 0; o < 2; o++)
        for (int r = 0; r < 8; r++) begin
          tx  = 8'h3C + 8'((m * 16 + o * 8 + r) * 29);
          stx = {tx[3:0], tx[7:4]} ^ 8'h5A;
          do_reset();
          wr(2'd1, {7'b0, r[2]});
          wr(2'd0, {2'b01, o[0], 1'b1, m[1], m[0], r[1:0]});
          sl_reset(m[0], o[0], stx);
          chk("R4 idle level", sck_o, m[1]);
          wr(2'd2, tx);
          while (sl_bytes == 0) @(negedge clk);
          repeat (3) @(negedge clk);
          chk("R5 R6 slave got", sl_last, tx);
          rd(2'd2, v); chk("R5 R6 master got", v, stx);
          chk("R7 period", t_last - t_first, 15 * (r < 2 ? 2 + r : (r == 2 ? 4 :
              (r == 3 ? 6 : (r == 4 ? 8 : (r == 5 ? 12 : (r == 6 ? 24 : 48)))))));
          rd(2'd1, v); chk("R8 flag set", v[7], 1); chk("R8 irq", irq, 1);
          chk("R4 idle after", sck_o, m[1]);
          if (m == 0 && o == 0) begin
            wr(2'd1, {7'b0, r[2]}); rd(2'd1, v); chk("R8 write0 keeps", v[7], 1);
            wr(2'd1, {1'b1, 6'b0, r[2]}); rd(2'd1, v); chk("R8 write1 clears", v[7], 0);
            chk("R8 irq cleared", irq, 0);
          end
        end

    // R10 R9 back to back at /4
    do_reset();
    wr(2'd0, 8'hD0); sl_reset(0, 0, 8'hC3);
    wr(2'd2, 8'h12);
    rd(2'd1, v); nb = 0;
    while (v[6] && nb < 50) begin rd(2'd1, v); nb++; end
    chk("R9 moved to shifter", v[6], 0);
    wr(2'd2, 8'hE7);
    rd(2'd1, v); chk("R9 full after write", v[6], 1);
    while (sl_bytes < 2) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R10 no gap", t_last - t_first, 31 * 2);
    chk("R10 first byte", sl_b0, 8'h12);
    chk("R10 second byte", sl_last, 8'hE7);

    // R3 mode change mid transfer
    do_reset();
    wr(2'd1, 8'h01); wr(2'd0, 8'h53); sl_reset(0, 0, 8'h00);
    wr(2'd2, 8'hAA); repeat (200) @(negedge clk);
    ss_n_i = 0; repeat (4) @(negedge clk);
    rd(2'd0, v); chk("R3 master bit dropped", v[4], 0);
    rd(2'd1, v); chk("R3 flag", v[7], 1);
    chk("R3 now slave", {sck_oe, mosi_oe, miso_oe}, 3'b001);
    nb = nedges; repeat (200) @(negedge clk);
    chk("R3 clock stopped", nedges, nb);

    // R12 slave modes 0 and 3
    for (int k = 0; k < 2; k++) begin
      do_reset();
      wr(2'd0, k ? 8'h4C : 8'h40);
      sck_i = k[0];
      wr(2'd2, k ? 8'h6B : 8'h94);
      repeat (4) @(negedge clk);
      rd(2'd1, v); chk("R9 slave loaded", v[6], 0);
      ext_master(k[0], k[0], k ? 8'h2D : 8'hB1, got);
      repeat (8) @(negedge clk);
      chk("R12 slave sent", got, k ? 8'h6B : 8'h94);
      rd(2'd2, v); chk("R12 slave received", v, k ? 8'h2D : 8'hB1);
      rd(2'd1, v); chk("R12 flag", v[7], 1);
    end

    summary();
  end
endmodule